// File: doc/BRIEF.md
# Display Auxiliary Channel Transaction Sequencer

This block carries out a single request/reply exchange on a display auxiliary channel for a host. The host gives a command code, a 20-bit target address, a byte count of 1 to 16 and, for writes, up to 16 payload bytes packed into four 32-bit words. It then pulses `host_start`. The sequencer claims the channel and confirms the claim. It polls the channel until it is ready and then launches the request. While the sink answers with a defer reply, it launches the request again, up to a fixed limit. When the exchange ends it reports a status code, the reply code and, for reads, the returned data.

The channel itself is modelled as a plain request/reply port. The block drives the request fields, a one-cycle launch strobe and an ownership request. It observes an ownership acknowledge, a ready flag, a busy flag and the reply code, byte count and data. All waits come from one down-counter whose lengths are given in microseconds and scaled by a clocks-per-microsecond parameter. Whatever the outcome, the block gives up the channel, confirms the release and waits a settle period before it signals completion.

Top module: `aux_xact_seq`

## Requirements
- R1: While reset is held and in the cycle after it, `host_busy`, `host_done`, `ch_own_req` and `ch_start` are 0 and `host_status` is 0.
- R2: An accepted start raises `ch_own_req`. If `ch_own_ack` is not 1 when sampled OWN_LAT cycles later, the transaction ends with status 1 (I/O error) and `ch_start` is never pulsed.
- R3: `ch_ready` is sampled at most READY_POLLS times, READY_GAP_US microseconds apart. If it is never 1, the status is 2 (busy error) and no request is launched. If it becomes 1 at a later poll, the transfer proceeds.
- R4: From acceptance to completion the channel fields are held stable: `ch_cmd` equals `host_cmd`, `ch_addr` equals `host_addr`, `ch_len` equals `host_count` minus one and `ch_wdata` equals `host_wdata`.
- R5: Each attempt is a `ch_start` pulse exactly one cycle wide. If `ch_busy` is still 1 BUSY_TIMEOUT_US microseconds after the launch, the status is 2.
- R6: The reply is sampled SETTLE_US microseconds after `ch_busy` clears. A reply whose bits [1:0] equal 2'b10 (defer) causes a new attempt. After MAX_TRIES attempts have all been deferred, the status is 3 (remote error) and `host_reply` shows the defer code.
- R7: Bit 0 of the command set to 1 marks a read. For a read, `ch_rcount` not equal to the requested count gives status 3. Otherwise the status is 0, `host_rdata` takes `ch_rdata` and `host_reply` takes `ch_reply`. `host_rdata` reads zero after a write or a failed read.
- R8: `ch_own_req` falls on every exit path. If `ch_own_ack` is still 1 OWN_LAT cycles after it falls, the status becomes 1, overriding any earlier status. `host_done` follows the release by at least SETTLE_US microseconds.
- R9: `host_done` is a one-cycle pulse that ends the `host_busy` interval. A `host_start` seen while `host_busy` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_start | input | 1 | Start a transaction (taken only when idle) |
| host_cmd | input | 4 | Command code; bit 0 set means read (8 write, 9 read) |
| host_addr | input | 20 | Target address |
| host_count | input | 5 | Byte count, 1 to 16 |
| host_wdata | input | 128 | Write payload, four 32-bit words |
| host_busy | output | 1 | Transaction in flight |
| host_done | output | 1 | One-cycle completion pulse |
| host_status | output | 2 | 0 ok, 1 I/O error, 2 busy error, 3 remote error |
| host_reply | output | 4 | Last sampled reply code |
| host_rdata | output | 128 | Read data |
| ch_own_req | output | 1 | Channel ownership request |
| ch_own_ack | input | 1 | Channel ownership acknowledge |
| ch_ready | input | 1 | Channel ready for a request |
| ch_cmd | output | 4 | Request command |
| ch_addr | output | 20 | Request address |
| ch_len | output | 4 | Byte count minus one |
| ch_wdata | output | 128 | Request payload |
| ch_start | output | 1 | One-cycle launch strobe |
| ch_busy | input | 1 | Channel working on the request |
| ch_reply | input | 4 | Reply code; bits [1:0] = 2'b10 means defer |
| ch_rcount | input | 5 | Number of bytes in the reply |
| ch_rdata | input | 128 | Reply data, four 32-bit words |

## Verification
The assertions assume that `host_count` always lies between 1 and 16. They also assume that the channel raises `ch_busy` in the cycle after it sees `ch_start`, and that `ch_own_ack` follows `ch_own_req` within OWN_LAT cycles unless a fault is being modelled. The bench's channel model raises busy on the edge after the strobe and makes the acknowledge follow the request by one cycle. Its sweeps use only legal counts. Faults are injected one at a time through model controls that are changed only while the block is idle.

// File: rtl/aux_xact_pkg.sv
package aux_xact_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_CLAIM,
    S_POLL,
    S_GAP,
    S_LAUNCH,
    S_WBUSY,
    S_SETTLE,
    S_RELEASE,
    S_RCHK,
    S_TAIL
  } seq_state_t;

  localparam logic [1:0] XS_OK         = 2'd0;
  localparam logic [1:0] XS_IO_ERR     = 2'd1;
  localparam logic [1:0] XS_BUSY_ERR   = 2'd2;
  localparam logic [1:0] XS_REMOTE_ERR = 2'd3;

  localparam logic [1:0] RPL_DEFER = 2'b10;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/aux_xact_timer.sv
module aux_xact_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] value,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= value;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/aux_xact_store.sv
module aux_xact_store #(
  parameter int unsigned ADDR_W  = 20,
  parameter int unsigned CMD_W   = 4,
  parameter int unsigned WORDS   = 4,
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned REPLY_W = 4,
  parameter int unsigned CNT_W   = 5,
  parameter int unsigned LEN_W   = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    accept,
  input  logic [CMD_W-1:0]        host_cmd,
  input  logic [ADDR_W-1:0]       host_addr,
  input  logic [CNT_W-1:0]        host_count,
  input  logic [WORDS*WORD_W-1:0] host_wdata,
  input  logic                    cap_reply,
  input  logic                    cap_data,
  input  logic [REPLY_W-1:0]      ch_reply,
  input  logic [WORDS*WORD_W-1:0] ch_rdata,
  output logic [CMD_W-1:0]        ch_cmd,
  output logic [ADDR_W-1:0]       ch_addr,
  output logic [LEN_W-1:0]        ch_len,
  output logic [WORDS*WORD_W-1:0] ch_wdata,
  output logic                    is_read,
  output logic [CNT_W-1:0]        req_count,
  output logic [REPLY_W-1:0]      host_reply,
  output logic [WORDS*WORD_W-1:0] host_rdata
);

  localparam int unsigned PAD_W = CNT_W - LEN_W;

  logic [CMD_W-1:0]   cmd_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [LEN_W-1:0]   len_q;
  logic [REPLY_W-1:0] reply_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q   <= '0;
      addr_q  <= '0;
      len_q   <= '0;
      reply_q <= '0;
    end else begin
      if (accept) begin
        cmd_q   <= host_cmd;
        addr_q  <= host_addr;
        len_q   <= LEN_W'(host_count - CNT_W'(1));
        reply_q <= '0;
      end else if (cap_reply) begin
        reply_q <= ch_reply;
      end
    end
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [WORD_W-1:0] wr_q;
    logic [WORD_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        wr_q <= '0;
        rd_q <= '0;
      end else if (accept) begin
        wr_q <= host_wdata[w*WORD_W +: WORD_W];
        rd_q <= '0;
      end else if (cap_data) begin
        rd_q <= ch_rdata[w*WORD_W +: WORD_W];
      end
    end

    assign ch_wdata[w*WORD_W +: WORD_W]   = wr_q;
    assign host_rdata[w*WORD_W +: WORD_W] = rd_q;
  end

  assign ch_cmd     = cmd_q;
  assign ch_addr    = addr_q;
  assign ch_len     = len_q;
  assign is_read    = cmd_q[0];
  assign req_count  = {{PAD_W{1'b0}}, len_q} + CNT_W'(1);
  assign host_reply = reply_q;

endmodule

// File: rtl/aux_xact_fsm.sv
module aux_xact_fsm
  import aux_xact_pkg::*;
#(
  parameter int unsigned CNT_W     = 5,
  parameter int unsigned TMR_W     = 8,
  parameter int unsigned POLLS     = 3,
  parameter int unsigned MAX_TRIES = 16,
  parameter int unsigned OWN_CYC   = 2,
  parameter int unsigned GAP_CYC   = 100,
  parameter int unsigned SETTLE_CYC = 400,
  parameter int unsigned BUSY_CYC  = 1000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_start,
  input  logic             is_read,
  input  logic [CNT_W-1:0] req_count,
  input  logic             ch_own_ack,
  input  logic             ch_ready,
  input  logic             ch_busy,
  input  logic [1:0]       rpl_low,
  input  logic [CNT_W-1:0] ch_rcount,
  input  logic             tmr_exp,
  output logic             tmr_load,
  output logic [TMR_W-1:0] tmr_value,
  output logic             accept,
  output logic             own_req,
  output logic             ch_start,
  output logic             host_busy,
  output logic             host_done,
  output logic [1:0]       status,
  output logic             cap_reply,
  output logic             cap_data
);

  localparam int unsigned TRY_W  = $clog2(MAX_TRIES + 1);
  localparam int unsigned POLL_W = $clog2(POLLS + 1);

  seq_state_t        st_q, st_d;
  logic [TRY_W-1:0]  tries_q, tries_d;
  logic [POLL_W-1:0] polls_q, polls_d;
  logic [1:0]        err_q, err_d;
  logic              own_q, own_d;
  logic              launch_q, launch_d;
  logic              done_q, done_d;
  logic              busy_q;

  always_comb begin
    st_d      = st_q;
    tries_d   = tries_q;
    polls_d   = polls_q;
    err_d     = err_q;
    own_d     = own_q;
    launch_d  = 1'b0;
    done_d    = 1'b0;
    tmr_load  = 1'b0;
    tmr_value = '0;
    accept    = 1'b0;
    cap_reply = 1'b0;
    cap_data  = 1'b0;
    case (st_q)
      S_IDLE: begin
        if (host_start) begin
          accept    = 1'b1;
          own_d     = 1'b1;
          err_d     = XS_OK;
          tries_d   = '0;
          polls_d   = '0;
          tmr_load  = 1'b1;
          tmr_value = TMR_W'(OWN_CYC);
          st_d      = S_CLAIM;
        end
      end
      S_CLAIM: begin
        if (tmr_exp) begin
          if (ch_own_ack) begin
            st_d = S_POLL;
          end else begin
            err_d = XS_IO_ERR;
            st_d  = S_RELEASE;
          end
        end
      end
      S_POLL: begin
        if (ch_ready) begin
          launch_d = 1'b1;
          tries_d  = tries_q + 1'b1;
          st_d     = S_LAUNCH;
        end else if (polls_q == POLL_W'(POLLS - 1)) begin
          err_d = XS_BUSY_ERR;
          st_d  = S_RELEASE;
        end else begin
          polls_d   = polls_q + 1'b1;
          tmr_load  = 1'b1;
          tmr_value = TMR_W'(GAP_CYC);
          st_d      = S_GAP;
        end
      end
      S_GAP: begin
        if (tmr_exp) st_d = S_POLL;
      end
      S_LAUNCH: begin
        tmr_load  = 1'b1;
        tmr_value = TMR_W'(BUSY_CYC);
        st_d      = S_WBUSY;
      end
      S_WBUSY: begin
        if (!ch_busy) begin
          tmr_load  = 1'b1;
          tmr_value = TMR_W'(SETTLE_CYC);
          st_d      = S_SETTLE;
        end else if (tmr_exp) begin
          err_d = XS_BUSY_ERR;
          st_d  = S_RELEASE;
        end
      end
      S_SETTLE: begin
        if (tmr_exp) begin
          if (rpl_low == RPL_DEFER) begin
            if (tries_q == TRY_W'(MAX_TRIES)) begin
              cap_reply = 1'b1;
              err_d     = XS_REMOTE_ERR;
              st_d      = S_RELEASE;
            end else begin
              launch_d = 1'b1;
              tries_d  = tries_q + 1'b1;
              st_d     = S_LAUNCH;
            end
          end else if (is_read && (ch_rcount != req_count)) begin
            cap_reply = 1'b1;
            err_d     = XS_REMOTE_ERR;
            st_d      = S_RELEASE;
          end else begin
            cap_reply = 1'b1;
            cap_data  = is_read;
            st_d      = S_RELEASE;
          end
        end
      end
      S_RELEASE: begin
        own_d     = 1'b0;
        tmr_load  = 1'b1;
        tmr_value = TMR_W'(OWN_CYC);
        st_d      = S_RCHK;
      end
      S_RCHK: begin
        if (tmr_exp) begin
          if (ch_own_ack) err_d = XS_IO_ERR;
          tmr_load  = 1'b1;
          tmr_value = TMR_W'(SETTLE_CYC);
          st_d      = S_TAIL;
        end
      end
      S_TAIL: begin
        if (tmr_exp) begin
          done_d = 1'b1;
          st_d   = S_IDLE;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= S_IDLE;
      tries_q  <= '0;
      polls_q  <= '0;
      err_q    <= XS_OK;
      own_q    <= 1'b0;
      launch_q <= 1'b0;
      done_q   <= 1'b0;
      busy_q   <= 1'b0;
    end else begin
      st_q     <= st_d;
      tries_q  <= tries_d;
      polls_q  <= polls_d;
      err_q    <= err_d;
      own_q    <= own_d;
      launch_q <= launch_d;
      done_q   <= done_d;
      busy_q   <= (st_d != S_IDLE);
    end
  end

  assign own_req   = own_q;
  assign ch_start  = launch_q;
  assign host_busy = busy_q;
  assign host_done = done_q;
  assign status    = err_q;

  AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
    ch_start |=> !ch_start) else $error("launch strobe wider than one cycle"); // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    host_done |=> !host_done) else $error("done wider than one cycle"); // R9

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    host_done |-> ($past(host_busy) && !host_busy)) else $error("done outside busy window"); // R9

  always_ff @(posedge clk) begin
    if (!rst) begin
      AST_TRIES_BOUND: assert (tries_q <= TRY_W'(MAX_TRIES)) else $error("attempt limit exceeded"); // R6
      AST_POLLS_BOUND: assert (polls_q < POLL_W'(POLLS)) else $error("poll limit exceeded"); // R3
    end
  end

endmodule

// File: rtl/aux_xact_seq.sv
module aux_xact_seq
  import aux_xact_pkg::*;
#(
  parameter int unsigned CLK_PER_US      = 100,
  parameter int unsigned ADDR_W          = 20,
  parameter int unsigned CMD_W           = 4,
  parameter int unsigned WORDS           = 4,
  parameter int unsigned WORD_W          = 32,
  parameter int unsigned REPLY_W         = 4,
  parameter int unsigned READY_POLLS     = 3,
  parameter int unsigned READY_GAP_US    = 100,
  parameter int unsigned SETTLE_US       = 400,
  parameter int unsigned MAX_TRIES       = 16,
  parameter int unsigned BUSY_TIMEOUT_US = 1000,
  parameter int unsigned OWN_LAT         = 2
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               host_start,
  input  logic [CMD_W-1:0]                   host_cmd,
  input  logic [ADDR_W-1:0]                  host_addr,
  input  logic [$clog2(WORDS*WORD_W/8+1)-1:0] host_count,
  input  logic [WORDS*WORD_W-1:0]            host_wdata,
  output logic                               host_busy,
  output logic                               host_done,
  output logic [1:0]                         host_status,
  output logic [REPLY_W-1:0]                 host_reply,
  output logic [WORDS*WORD_W-1:0]            host_rdata,
  output logic                               ch_own_req,
  input  logic                               ch_own_ack,
  input  logic                               ch_ready,
  output logic [CMD_W-1:0]                   ch_cmd,
  output logic [ADDR_W-1:0]                  ch_addr,
  output logic [$clog2(WORDS*WORD_W/8)-1:0]  ch_len,
  output logic [WORDS*WORD_W-1:0]            ch_wdata,
  output logic                               ch_start,
  input  logic                               ch_busy,
  input  logic [REPLY_W-1:0]                 ch_reply,
  input  logic [$clog2(WORDS*WORD_W/8+1)-1:0] ch_rcount,
  input  logic [WORDS*WORD_W-1:0]            ch_rdata
);

  localparam int unsigned DATA_W     = WORDS * WORD_W;
  localparam int unsigned MAX_BYTES  = DATA_W / 8;
  localparam int unsigned CNT_W      = $clog2(MAX_BYTES + 1);
  localparam int unsigned LEN_W      = $clog2(MAX_BYTES);
  localparam int unsigned GAP_CYC    = READY_GAP_US * CLK_PER_US;
  localparam int unsigned SETTLE_CYC = SETTLE_US * CLK_PER_US;
  localparam int unsigned BUSY_CYC   = BUSY_TIMEOUT_US * CLK_PER_US;
  localparam int unsigned MAX_CYC    = max_u(max_u(GAP_CYC, SETTLE_CYC), max_u(BUSY_CYC, OWN_LAT));
  localparam int unsigned TMR_W      = $clog2(MAX_CYC + 1);

  logic             tmr_load;
  logic [TMR_W-1:0] tmr_value;
  logic             tmr_exp;
  logic             accept;
  logic             cap_reply;
  logic             cap_data;
  logic             is_read;
  logic [CNT_W-1:0] req_count;

  aux_xact_timer #(
    .CNT_W(TMR_W)
  ) timer_i (
    .clk     (clk),
    .rst     (rst),
    .load    (tmr_load),
    .value   (tmr_value),
    .expired (tmr_exp)
  );

  aux_xact_fsm #(
    .CNT_W      (CNT_W),
    .TMR_W      (TMR_W),
    .POLLS      (READY_POLLS),
    .MAX_TRIES  (MAX_TRIES),
    .OWN_CYC    (OWN_LAT),
    .GAP_CYC    (GAP_CYC),
    .SETTLE_CYC (SETTLE_CYC),
    .BUSY_CYC   (BUSY_CYC)
  ) fsm_i (
    .clk        (clk),
    .rst        (rst),
    .host_start (host_start),
    .is_read    (is_read),
    .req_count  (req_count),
    .ch_own_ack (ch_own_ack),
    .ch_ready   (ch_ready),
    .ch_busy    (ch_busy),
    .rpl_low    (ch_reply[1:0]),
    .ch_rcount  (ch_rcount),
    .tmr_exp    (tmr_exp),
    .tmr_load   (tmr_load),
    .tmr_value  (tmr_value),
    .accept     (accept),
    .own_req    (ch_own_req),
    .ch_start   (ch_start),
    .host_busy  (host_busy),
    .host_done  (host_done),
    .status     (host_status),
    .cap_reply  (cap_reply),
    .cap_data   (cap_data)
  );

  aux_xact_store #(
    .ADDR_W  (ADDR_W),
    .CMD_W   (CMD_W),
    .WORDS   (WORDS),
    .WORD_W  (WORD_W),
    .REPLY_W (REPLY_W),
    .CNT_W   (CNT_W),
    .LEN_W   (LEN_W)
  ) store_i (
    .clk        (clk),
    .rst        (rst),
    .accept     (accept),
    .host_cmd   (host_cmd),
    .host_addr  (host_addr),
    .host_count (host_count),
    .host_wdata (host_wdata),
    .cap_reply  (cap_reply),
    .cap_data   (cap_data),
    .ch_reply   (ch_reply),
    .ch_rdata   (ch_rdata),
    .ch_cmd     (ch_cmd),
    .ch_addr    (ch_addr),
    .ch_len     (ch_len),
    .ch_wdata   (ch_wdata),
    .is_read    (is_read),
    .req_count  (req_count),
    .host_reply (host_reply),
    .host_rdata (host_rdata)
  );

  AST_START_OWNED: assert property (@(posedge clk) disable iff (rst)
    ch_start |-> ch_own_req) else $error("launch without ownership"); // R2

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (ch_own_req && $past(ch_own_req)) |->
      ($stable(ch_addr) && $stable(ch_cmd) && $stable(ch_len) && $stable(ch_wdata)))
    else $error("request fields moved while owned"); // R4

  AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    host_done |-> !ch_own_req) else $error("done while still owning channel"); // R8

  AST_NO_START_IDLE: assert property (@(posedge clk) disable iff (rst)
    !host_busy |-> !ch_start) else $error("launch outside transaction"); // R9

endmodule

// File: tb/aux_xact_seq_tb.sv
module aux_xact_seq_tb_top;

  localparam int SETTLE = 400;
  localparam int WD_LIMIT = 195000;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst;
  logic         host_start;
  logic [3:0]   host_cmd;
  logic [19:0]  host_addr;
  logic [4:0]   host_count;
  logic [127:0] host_wdata;
  logic         host_busy, host_done;
  logic [1:0]   host_status;
  logic [3:0]   host_reply;
  logic [127:0] host_rdata;
  logic         ch_own_req, ch_own_ack, ch_ready;
  logic [3:0]   ch_cmd;
  logic [19:0]  ch_addr;
  logic [3:0]   ch_len;
  logic [127:0] ch_wdata;
  logic         ch_start, ch_busy;
  logic [3:0]   ch_reply;
  logic [4:0]   ch_rcount;
  logic [127:0] ch_rdata;

  aux_xact_seq #(
    .CLK_PER_US      (1),
    .BUSY_TIMEOUT_US (50)
  ) dut_i (
    .clk(clk), .rst(rst), .host_start(host_start), .host_cmd(host_cmd),
    .host_addr(host_addr), .host_count(host_count), .host_wdata(host_wdata),
    .host_busy(host_busy), .host_done(host_done), .host_status(host_status),
    .host_reply(host_reply), .host_rdata(host_rdata), .ch_own_req(ch_own_req),
    .ch_own_ack(ch_own_ack), .ch_ready(ch_ready), .ch_cmd(ch_cmd),
    .ch_addr(ch_addr), .ch_len(ch_len), .ch_wdata(ch_wdata), .ch_start(ch_start),
    .ch_busy(ch_busy), .ch_reply(ch_reply), .ch_rcount(ch_rcount), .ch_rdata(ch_rdata)
  );

  // channel model controls, changed only while the block is idle
  logic m_ack_never = 1'b0, m_ack_sticky = 1'b0, m_busy_stuck = 1'b0, m_rcount_bad = 1'b0;
  int   m_ready_delay = 0, m_defer_n = 0;
  logic [3:0] m_final = 4'h0;

  int starts_total = 0, start_base = 0, rdy_cnt = 0, busy_cnt = 0;
  logic [3:0]   cap_cmd, cap_len;
  logic [19:0]  cap_addr;
  logic [127:0] cap_wdata;

  function automatic logic [127:0] pat(input logic [19:0] a);
    logic [127:0] v;
    for (int i = 0; i < 4; i++) v[i*32 +: 32] = {a[11:0], a} ^ 32'(i * 32'h0F0F_1111);
    return v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      ch_own_ack <= 1'b0; ch_busy <= 1'b0; ch_reply <= '0; ch_rcount <= '0;
      ch_rdata <= '0; rdy_cnt <= 0; busy_cnt <= 0;
    end else begin
      if (m_ack_never) ch_own_ack <= 1'b0;
      else if (m_ack_sticky) ch_own_ack <= ch_own_ack | ch_own_req;
      else ch_own_ack <= ch_own_req;
      rdy_cnt <= ch_own_req ? rdy_cnt + 1 : 0;
      if (ch_start) begin
        starts_total <= starts_total + 1;
        ch_busy   <= 1'b1;
        busy_cnt  <= 3;
        ch_reply  <= ((starts_total - start_base) < m_defer_n) ? 4'h2 : m_final;
        ch_rcount <= 5'(int'(ch_len) + 1 + (m_rcount_bad ? 1 : 0));
        ch_rdata  <= pat(ch_addr);
        cap_cmd <= ch_cmd; cap_addr <= ch_addr; cap_len <= ch_len; cap_wdata <= ch_wdata;
      end else if (ch_busy && !m_busy_stuck) begin
        if (busy_cnt <= 1) ch_busy <= 1'b0;
        busy_cnt <= busy_cnt - 1;
      end
    end
  end

  assign ch_ready = ch_own_req && (rdy_cnt >= m_ready_delay);

  // monitor, sampled away from the active edge
  int cyc = 0, done_cnt = 0, done_cyc = 0, own_fall_cyc = 0;
  logic own_prev = 1'b0;
  always @(negedge clk) begin
    cyc <= cyc + 1;
    own_prev <= ch_own_req;
    if (own_prev && !ch_own_req) own_fall_cyc <= cyc;
    if (host_done) begin done_cnt <= done_cnt + 1; done_cyc <= cyc; end
  end

  int checks = 0, failures = 0;
  int last_elapsed, last_starts;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_xact(input logic [3:0] cmd, input logic [19:0] addr,
                          input int count, input logic [127:0] wd);
    int t0, d0;
    @(negedge clk);
    start_base = starts_total;
    host_cmd = cmd; host_addr = addr; host_count = 5'(count); host_wdata = wd;
    host_start = 1'b1;
    t0 = cyc; d0 = done_cnt;
    @(negedge clk);
    host_start = 1'b0;
    while (done_cnt == d0) @(negedge clk);
    @(negedge clk);
    last_elapsed = done_cyc - t0;
    last_starts  = starts_total - start_base;
  endtask

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=done", WD_LIMIT);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [19:0]  a;
    logic [127:0] wd;
    int d0, s0;
    rst = 1'b1; host_start = 1'b0; host_cmd = '0; host_addr = '0; host_count = 5'd1; host_wdata = '0;
    repeat (4) @(negedge clk);
    chk(!host_busy && !host_done && !ch_own_req && !ch_start && host_status == 2'd0,
        "R1", "outputs in reset", {host_busy, host_done, ch_own_req, ch_start, host_status}, '0);
    rst = 1'b0;
    @(negedge clk);
    chk(!host_busy && !host_done && !ch_own_req && !ch_start, "R1", "outputs after reset",
        {host_busy, host_done, ch_own_req, ch_start}, '0);

    // R4 / R7: sweep every count for writes and reads
    for (int rd = 0; rd < 2; rd++) begin
      for (int n = 1; n <= 16; n++) begin
        a  = 20'(20'h1000 + n * 33 + rd);
        wd = {4{32'(n * 32'h0101_0101)}} ^ {96'h0, 32'(a)};
        m_final = (n % 3 == 0) ? 4'h1 : ((n % 3 == 1) ? 4'h0 : 4'h4);
        run_xact(rd ? 4'd9 : 4'd8, a, n, wd);
        chk(host_status == 2'd0, "R7", "status", 128'(host_status), 0);
        chk(last_starts == 1, "R5", "attempts", 128'(last_starts), 1);
        chk(cap_len == 4'(n - 1), "R4", "length field", 128'(cap_len), 128'(n - 1));
        chk(cap_addr == a && cap_cmd == (rd ? 4'd9 : 4'd8), "R4", "addr/cmd",
            {cap_cmd, cap_addr}, {(rd ? 4'd9 : 4'd8), a});
        chk(cap_wdata == wd, "R4", "payload", cap_wdata, wd);
        chk(host_rdata == (rd ? pat(a) : 128'h0), "R7", "read data", host_rdata, rd ? pat(a) : 128'h0);
        chk(host_reply == m_final, "R7", "reply code", 128'(host_reply), 128'(m_final));
        chk(!ch_own_req && (done_cyc - own_fall_cyc) >= SETTLE, "R8", "release then settle",
            128'(done_cyc - own_fall_cyc), 128'(SETTLE));
      end
    end
    m_final = 4'h0;

    // R7: read length mismatch, write ignores count
    m_rcount_bad = 1'b1;
    run_xact(4'd9, 20'h00ABC, 4, '0);
    chk(host_status == 2'd3, "R7", "read count mismatch", 128'(host_status), 3);
    chk(host_rdata == '0, "R7", "no data on mismatch", host_rdata, '0);
    run_xact(4'd8, 20'h00ABD, 4, 128'h55);
    chk(host_status == 2'd0, "R7", "write ignores count", 128'(host_status), 0);
    m_rcount_bad = 1'b0;

    // R2: ownership never acknowledged
    m_ack_never = 1'b1;
    run_xact(4'd9, 20'h12345, 2, '0);
    chk(host_status == 2'd1, "R2", "no ack status", 128'(host_status), 1);
    chk(last_starts == 0, "R2", "no launch without ack", 128'(last_starts), 0);
    m_ack_never = 1'b0;

    // R8: acknowledge stuck after release
    m_ack_sticky = 1'b1;
    run_xact(4'd9, 20'h22222, 3, '0);
    chk(host_status == 2'd1, "R8", "ack stuck status", 128'(host_status), 1);
    chk(last_starts == 1, "R8", "transfer before release", 128'(last_starts), 1);
    m_ack_sticky = 1'b0;
    repeat (4) @(negedge clk);

    // R3: ready polling
    m_ready_delay = 100000;
    run_xact(4'd8, 20'h33333, 1, '0);
    chk(host_status == 2'd2, "R3", "never ready", 128'(host_status), 2);
    chk(last_starts == 0, "R3", "no launch when not ready", 128'(last_starts), 0);
    m_ready_delay = 150;
    run_xact(4'd8, 20'h33334, 1, '0);
    chk(host_status == 2'd0, "R3", "ready at third poll", 128'(host_status), 0);
    chk(last_elapsed >= 200 + 2 * SETTLE, "R3", "poll gaps", 128'(last_elapsed), 128'(200 + 2 * SETTLE));
    m_ready_delay = 250;
    run_xact(4'd8, 20'h33335, 1, '0);
    chk(host_status == 2'd2, "R3", "ready too late", 128'(host_status), 2);
    m_ready_delay = 0;

    // R5: busy never clears
    m_busy_stuck = 1'b1;
    run_xact(4'd9, 20'h44444, 8, '0);
    chk(host_status == 2'd2, "R5", "busy timeout", 128'(host_status), 2);
    chk(last_starts == 1, "R5", "single launch", 128'(last_starts), 1);
    m_busy_stuck = 1'b0;
    repeat (8) @(negedge clk);

    // R6: defer sweep
    for (int n = 0; n <= 16; n++) begin
      int exp_s;
      m_defer_n = n;
      m_final = 4'h0;
      run_xact(4'd9, 20'(20'h50000 + n), 2, '0);
      exp_s = (n < 16) ? n + 1 : 16;
      chk(last_starts == exp_s, "R6", "attempt count", 128'(last_starts), 128'(exp_s));
      chk(host_status == ((n < 16) ? 2'd0 : 2'd3), "R6", "status after defers",
          128'(host_status), (n < 16) ? 0 : 3);
      chk(host_reply == ((n < 16) ? 4'h0 : 4'h2), "R6", "reply after defers",
          128'(host_reply), (n < 16) ? 0 : 2);
      chk(last_elapsed >= (exp_s + 1) * SETTLE && last_elapsed <= (exp_s + 1) * SETTLE + 12 * exp_s + 40,
          "R6", "settle timing", 128'(last_elapsed), 128'((exp_s + 1) * SETTLE));
    end
    m_defer_n = 0;

    // R9: start ignored while in flight
    m_defer_n = 2;
    @(negedge clk);
    start_base = starts_total;
    s0 = starts_total; d0 = done_cnt;
    host_cmd = 4'd9; host_addr = 20'h60000; host_count = 5'd5; host_start = 1'b1;
    @(negedge clk);
    host_start = 1'b0;
    repeat (300) @(negedge clk);
    chk(host_busy, "R9", "busy in flight", 128'(host_busy), 1);
    host_cmd = 4'd8; host_addr = 20'h7FFFF; host_count = 5'd1; host_start = 1'b1;
    @(negedge clk);
    host_start = 1'b0;
    while (done_cnt == d0) @(negedge clk);
    repeat (600) @(negedge clk);
    chk(done_cnt == d0 + 1, "R9", "single completion", 128'(done_cnt - d0), 1);
    chk(starts_total - s0 == 3, "R9", "no extra launches", 128'(starts_total - s0), 3);
    chk(cap_addr == 20'h60000 && !host_busy && !ch_own_req, "R9", "first request kept",
        128'(cap_addr), 128'(20'h60000));
    chk(host_rdata == pat(20'h60000), "R9", "first request data", host_rdata, pat(20'h60000));
    m_defer_n = 0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule